// File: doc/BRIEF.md
# Posted Video-RAM Write Buffer

This block sits between a CPU bus and a private video RAM bus. A CPU write that lands inside the video address window is not sent to video RAM straight away. It goes into a small first-in, first-out queue of address/data pairs, and the mirror copy held in system RAM is updated in the same cycle. The queue empties into video RAM one entry at a time, and only in cycles where the video fetch engine has released its bus. The fetch engine reports that it owns the bus through an address-enable style busy input.

CPU reads of the window are sent to the mirror copy, so they never wait. A fetch burst can hold the video bus for 62 to 65 cycles in a row. During such a burst the CPU is stalled only when a window write finds the queue full. The stall ends once a free slot has drained an entry.

Top module: `vram_post_buf`

## Requirements
- R1: After reset the queue is empty. `vramWe` and `cpuWait` are 0.
- R2: A write (`cpuWr`=1) to an address in [WIN_LO, WIN_HI] (default 0x4000..0x7FFF) that is not stalled raises `mirWe` in the same cycle, with `mirAddr`/`mirWdata` equal to the CPU address and data, and `cpuWait`=0. The entry is queued at that clock edge.
- R3: The queue never holds more than DEPTH entries (default 16). A window write made while DEPTH entries are pending raises `cpuWait`, holds `mirWe` at 0 and queues nothing.
- R4: `vramWe` is 1 only in cycles where `vidBusy`=0. While `vidBusy`=1 no entry leaves the queue, however long the burst lasts.
- R5: Entries leave in strict arrival order, at most one per cycle. In any cycle with `vidBusy`=0 and a non-empty queue, `vramWe`=1 and `vramAddr`/`vramWdata` show the oldest entry. That entry is removed at the end of the cycle.
- R6: An entry queued at a clock edge can be presented to video RAM no earlier than the cycle after that edge.
- R7: A read (`cpuRd`=1) of a window address raises `mirRe` in the same cycle and never raises `cpuWait`, even when the queue is full.
- R8: Reads and writes outside the window raise neither mirror strobe nor `cpuWait`, and queue nothing.
- R9: A stalled window write is released in the cycle after a single free slot has drained one entry. From then on it is accepted like any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWdata | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write request |
| cpuRd | input | 1 | CPU read request |
| vidBusy | input | 1 | Video fetch engine owns the video bus |
| cpuWait | output | 1 | Stall the CPU (window write with the queue full) |
| mirWe | output | 1 | Mirror RAM write strobe |
| mirRe | output | 1 | Mirror RAM read strobe |
| mirAddr | output | 16 | Mirror RAM address |
| mirWdata | output | 8 | Mirror RAM write data |
| vramWe | output | 1 | Video RAM write strobe |
| vramAddr | output | 16 | Video RAM write address |
| vramWdata | output | 8 | Video RAM write data |

## Verification
The mirror strobes, `cpuWait` and the video write strobe with the oldest entry are combinational. They are due in the same cycle as the stimulus that causes them. Queue contents change only at the next rising edge, so a newly pushed entry or a released stall is due one cycle later. The bench drives its inputs at the falling edge and checks these same-cycle outputs one nanosecond later. It then steps a full clock before it checks any result that depends on a register.

// File: rtl/vpb_pkg.sv
package vpb_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } vpbStrobe_t;
endpackage

// File: rtl/vpb_datapath.sv
module vpb_datapath
  import vpb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  vpbStrobe_t    strb,
  input  logic [AW-1:0] inAddr,
  input  logic [DW-1:0] inData,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0] addrMem [DEPTH];
  logic [DW-1:0] dataMem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      addrMem[wrPtr] <= inAddr;
      dataMem[wrPtr] <= inData;
    end
  end

  assign headAddr = addrMem[rdPtr];
  assign headData = dataMem[rdPtr];

  // R5: every pop moves the read pointer by exactly one slot
  p_pop_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> rdPtr == nextPtr($past(rdPtr)));
  // R3: a cycle without a push leaves the write pointer in place
  p_hold_wrptr_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.push |=> $stable(wrPtr));
endmodule

// File: rtl/vpb_ctrl.sv
module vpb_ctrl
  import vpb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter logic [AW-1:0] WIN_LO = 16'h4000,
  parameter logic [AW-1:0] WIN_HI = 16'h7FFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] cpuAddr,
  input  logic          cpuWr,
  input  logic          cpuRd,
  input  logic          vidBusy,
  output vpbStrobe_t    strb,
  output logic          cpuWait,
  output logic          mirWe,
  output logic          mirRe,
  output logic          vramWe
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [CW-1:0] count;
  logic inWin, full, empty;

  assign inWin = (cpuAddr >= WIN_LO) && (cpuAddr <= WIN_HI);
  assign full  = (count == FULLCNT);
  assign empty = (count == '0);

  assign cpuWait   = cpuWr & inWin & full;
  assign strb.push = cpuWr & inWin & ~full;
  assign strb.pop  = ~vidBusy & ~empty;
  assign mirWe     = strb.push;
  assign mirRe     = cpuRd & inWin;
  assign vramWe    = strb.pop;

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (strb.push && !strb.pop) count <= count + 1'b1;
    else if (!strb.push && strb.pop) count <= count - 1'b1;
  end

  // R3: the queue never overflows
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULLCNT);
  // R4: video RAM is written only in free slots
  p_free_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    vramWe |-> !vidBusy);
  // R4: nothing drains during a fetch burst
  p_busy_no_drain_r4: assert property (@(posedge clk) disable iff (!rstN)
    vidBusy |=> count >= $past(count));
  // R5: occupancy changes by at most one per cycle
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    32'(count) <= 32'($past(count)) + 1 && 32'(count) + 1 >= 32'($past(count)));
  // R2: the mirror is never written by a stalled access
  p_mirror_not_stalled_r2: assert property (@(posedge clk) disable iff (!rstN)
    mirWe |-> !cpuWait);
  // R7: a read strobe on its own never stalls
  p_read_no_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mirRe && !cpuWr) |-> !cpuWait);
endmodule

// File: rtl/vram_post_buf.sv
module vram_post_buf
  import vpb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter logic [15:0] WIN_LO = 16'h4000,
  parameter logic [15:0] WIN_HI = 16'h7FFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWdata,
  input  logic        cpuWr,
  input  logic        cpuRd,
  input  logic        vidBusy,
  output logic        cpuWait,
  output logic        mirWe,
  output logic        mirRe,
  output logic [15:0] mirAddr,
  output logic [7:0]  mirWdata,
  output logic        vramWe,
  output logic [15:0] vramAddr,
  output logic [7:0]  vramWdata
);
  vpbStrobe_t strb;

  vpb_ctrl #(.DEPTH(DEPTH), .AW(16), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .vidBusy(vidBusy), .strb(strb), .cpuWait(cpuWait), .mirWe(mirWe),
    .mirRe(mirRe), .vramWe(vramWe)
  );

  vpb_datapath #(.DEPTH(DEPTH), .AW(16), .DW(8)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inAddr(cpuAddr), .inData(cpuWdata),
    .headAddr(vramAddr), .headData(vramWdata)
  );

  assign mirAddr  = cpuAddr;
  assign mirWdata = cpuWdata;
endmodule

// File: tb/tb_vram_post_buf.sv
`timescale 1ns/100ps
module tb_vram_post_buf;
  logic clk = 0, rstN = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0] cpuWdata = 0;
  logic cpuWr = 0, cpuRd = 0, vidBusy = 1;
  logic cpuWait, mirWe, mirRe, vramWe;
  logic [15:0] mirAddr, vramAddr;
  logic [7:0] mirWdata, vramWdata;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  vram_post_buf dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at falling edge, settle 1ns
  task automatic drive(input logic wr, input logic rd, input logic [15:0] a,
                       input logic [7:0] d, input logic busy);
    @(negedge clk);
    cpuWr = wr; cpuRd = rd; cpuAddr = a; cpuWdata = d; vidBusy = busy;
    #1;
  endtask

  task automatic idle(input logic busy);
    drive(0, 0, 16'h0000, 8'h00, busy);
  endtask

  task automatic t_reset;
    rstN = 0; idle(1); idle(1);
    @(negedge clk); rstN = 1; vidBusy = 0; #1;
    chk("R1 vramWe", vramWe, 0);
    chk("R1 cpuWait", cpuWait, 0);
    idle(0);
    chk("R1 empty", vramWe, 0);
  endtask

  task automatic t_post_and_drain;
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, 16'h4000 + 16'(i), 8'hA0 + 8'(i), 1);
      chk("R2 mirWe", mirWe, 1);
      chk("R2 mirAddr", mirAddr, 16'h4000 + 16'(i));
      chk("R2 mirWdata", mirWdata, 8'hA0 + 8'(i));
      chk("R2 wait", cpuWait, 0);
    end
    drive(1, 0, 16'h1234, 8'h55, 1);
    chk("R8 wr mirWe", mirWe, 0);
    chk("R8 wr wait", cpuWait, 0);
    drive(0, 1, 16'h8000, 8'h00, 1);
    chk("R8 rd mirRe", mirRe, 0);
    for (int i = 0; i < 3; i++) begin
      idle(0);
      chk("R5 vramWe", vramWe, 1);
      chk("R5 order addr", vramAddr, 16'h4000 + 16'(i));
      chk("R5 order data", vramWdata, 8'hA0 + 8'(i));
    end
    idle(0);
    chk("R8 nothing queued", vramWe, 0);
  endtask

  task automatic t_visible_next;
    drive(1, 0, 16'h7FFF, 8'h3C, 0);
    chk("R6 not same cycle", vramWe, 0);
    idle(0);
    chk("R6 next cycle", vramWe, 1);
    chk("R6 addr", vramAddr, 16'h7FFF);
    idle(0);
    chk("R6 drained", vramWe, 0);
  endtask

  task automatic t_full_stall;
    for (int i = 0; i < 16; i++) drive(1, 0, 16'h5000 + 16'(i), 8'(i), 1);
    drive(1, 0, 16'h5100, 8'hEE, 1);
    chk("R3 wait when full", cpuWait, 1);
    chk("R3 no mirror", mirWe, 0);
    drive(0, 1, 16'h5000, 8'h00, 1);
    chk("R7 mirRe", mirRe, 1);
    chk("R7 no wait", cpuWait, 0);
    for (int i = 0; i < 64; i++) begin
      drive(1, 0, 16'h5100, 8'hEE, 1);
      chk("R4 busy no drain", vramWe, 0);
    end
    drive(1, 0, 16'h5100, 8'hEE, 0);
    chk("R9 slot drains", vramWe, 1);
    chk("R9 head", vramAddr, 16'h5000);
    chk("R9 still waiting", cpuWait, 1);
    drive(1, 0, 16'h5100, 8'hEE, 1);
    chk("R9 released", cpuWait, 0);
    chk("R9 accepted", mirWe, 1);
    idle(1);
    for (int i = 1; i < 17; i++) begin
      idle(0);
      chk("R5 full order", vramAddr, (i == 16) ? 16'h5100 : 16'h5000 + 16'(i));
      chk("R5 full data", vramWdata, (i == 16) ? 8'hEE : 8'(i));
    end
    idle(0);
    chk("R5 empty", vramWe, 0);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_post_and_drain;
        t_visible_next;
        t_full_stall;
      end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule